// File: doc/BRIEF.md
# Subspace Designator Replacement Walker

This block decides whether an address-space designator has to be swapped for the designator of the subspace in which a dispatchable unit last ran. A single start pulse supplies the 64-bit designator, the space-entry origin that an earlier number translation produced, two control words, the prefix value and the highest valid memory address. Two quick tests can end the job with no memory traffic: the address-space-function enable and the designator's group bit.

When both tests pass, the block walks two tables through a 32-bit read port. The first is the unit control table. Its origin comes from control word 2. The second is the subspace entry, and its origin comes from that control table. Both origins are prefixed and checked against the memory limit before any read.

The walk ends in one of three ways. If the unit is not subspace-active, or the supplied origin is not its base entry, the original designator comes back. If the subspace entry is invalid or out of sequence, the result is zero with an exception code. Otherwise the result is the subspace designator, with the two event bits taken from the original. Completion is marked by a one-cycle `done`.

Top module: `ssr_walker`

## Requirements
- R1: When bit 16 of `ctl0` is 0, a start returns `result` equal to `des_in` and `exc_code` 0, with `done` high in the cycle after the start and no memory read.
- R2: When bit 9 of `des_in` is 0, a start returns `des_in` unchanged, with code 0, one cycle later and no memory read.
- R3: The control-table origin is `ctl2 & 32'h7FFF_FFC0` after prefixing. If it is greater than `mem_limit`, the block returns 0 with code 16'h0005 and makes no read.
- R4: Control-table words are read at origin+0, origin+4 and origin+12, in that order.
- R5: The original designator is returned with code 0 when bit 31 of control word +4 is 0, or when `asteo_in` differs from `(word +0) & 32'h7FFF_FFC0`.
- R6: The subspace-entry origin is `(control word +4) & 32'h7FFF_FFC0` after prefixing. If it is greater than `mem_limit`, the block returns 0 with code 16'h0005 after the three control reads.
- R7: Subspace-entry words are read at origin+0, +8, +12 and +20, in that order. The +12 read happens only when EXT_MODE=1.
- R8: If bit 31 of entry word +0 is 1, the block returns 0 with code 16'h002B. This check takes priority over the sequence check.
- R9: If entry word +20 differs from control word +12, the block returns 0 with code 16'h002C.
- R10: On success, code is 0. The result is the entry designator, which is {word +8, word +12} when EXT_MODE=1 and {32'h0, word +8} otherwise. Bits 7:6 of the result are taken from `des_in`.
- R11: Prefixing uses 4 KiB pages. An origin in page 0 maps to the prefix page (`prefix_in[31:12]`), an origin in the prefix page maps to page 0, and any other origin is unchanged.
- R12: `mem_req` stays high with `mem_addr` stable until `mem_ack`. A read is complete only on a cycle with both high. `done` lasts exactly one cycle, and `mem_req` is low while it is high.
- R13: A start that arrives while a walk is in progress is ignored. Only one `done` and the first request's result appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| start | input | 1 | request pulse, sampled when idle |
| des_in | input | 64 | original address-space designator |
| asteo_in | input | 32 | space-entry origin from number translation |
| ctl0 | input | 32 | control word 0 (bit 16 = enable) |
| ctl2 | input | 32 | control word 2 (control-table origin) |
| prefix_in | input | 32 | prefix register |
| mem_limit | input | 32 | highest valid absolute address |
| mem_req | output | 1 | read request |
| mem_addr | output | 32 | read byte address |
| mem_ack | input | 1 | read accepted, data valid |
| mem_rdata | input | 32 | read data |
| done | output | 1 | one-cycle completion pulse |
| result | output | 64 | resulting designator or zero |
| exc_code | output | 16 | 0, 16'h0005, 16'h002B or 16'h002C |

## Verification
The bench uses the default parameters: 32-bit addresses, a 64-bit designator, EXT_MODE=1 and 4 KiB pages. With extended mode, the full seven-read walk is reached, including the +12 entry word that supplies the low half of the replaced designator. The page size puts both page 0 and the prefix page (page 2) inside the bench's 16 KiB model memory, so the prefixing swap can be seen directly in the logged read addresses. The acknowledge latency is varied between zero and two wait cycles to exercise request holding.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_U0, S_U1, S_U3, S_UCHK, S_E0, S_E2, S_E3, S_E5, S_FIN
  } walk_st_t;

  localparam int CTL_ENABLE_BIT = 16;
  localparam int DES_GROUP_BIT  = 9;
  localparam int EV_LO          = 6;
  localparam int ACTIVE_BIT     = 31;
  localparam int INVALID_BIT    = 31;

  localparam logic [15:0] XC_ADDR  = 16'h0005;
  localparam logic [15:0] XC_VALID = 16'h002B;
  localparam logic [15:0] XC_SEQ   = 16'h002C;
endpackage

// File: rtl/ssr_prefix.sv
module ssr_prefix #(
  parameter int AW        = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] pfx,
  output logic [AW-1:0] phys
);
  localparam int PW = AW - PAGE_BITS;

  logic [PW-1:0] pg;
  logic          unused_pfx_low;

  assign pg             = addr[AW-1:PAGE_BITS];
  assign unused_pfx_low = ^pfx[PAGE_BITS-1:0];

  always_comb begin
    if (pg == '0)
      phys = {pfx[AW-1:PAGE_BITS], addr[PAGE_BITS-1:0]};
    else if (pg == pfx[AW-1:PAGE_BITS])
      phys = {{PW{1'b0}}, addr[PAGE_BITS-1:0]};
    else
      phys = addr;
  end
endmodule

// File: rtl/ssr_merge.sv
module ssr_merge #(
  parameter int DW       = 64,
  parameter int EXT_MODE = 1
) (
  input  logic [DW-1:0] orig,
  input  logic          ent_invalid,
  input  logic [31:0]   ent_w2,
  input  logic [31:0]   ent_w3,
  input  logic [31:0]   ent_seq,
  input  logic [31:0]   ref_seq,
  output logic [DW-1:0] res,
  output logic [15:0]   code
);
  import ssr_pkg::*;

  localparam logic [DW-1:0] EV_MASK = DW'(3) << EV_LO;

  logic [DW-1:0] ent_des;

  generate
    if (EXT_MODE != 0) begin : g_wide
      assign ent_des = DW'({ent_w2, ent_w3});
    end else begin : g_narrow
      logic unused_w3;
      assign unused_w3 = ^ent_w3;
      assign ent_des   = DW'(ent_w2);
    end
  endgenerate

  always_comb begin
    if (ent_invalid) begin
      res  = '0;
      code = XC_VALID;
    end else if (ent_seq != ref_seq) begin
      res  = '0;
      code = XC_SEQ;
    end else begin
      res  = (orig & EV_MASK) | (ent_des & ~EV_MASK);
      code = '0;
    end
  end
endmodule

// File: rtl/ssr_walker.sv
module ssr_walker #(
  parameter int AW        = 32,
  parameter int DW        = 64,
  parameter int EXT_MODE  = 1,
  parameter int PAGE_BITS = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] des_in,
  input  logic [AW-1:0] asteo_in,
  input  logic [31:0]   ctl0,
  input  logic [31:0]   ctl2,
  input  logic [AW-1:0] prefix_in,
  input  logic [AW-1:0] mem_limit,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          done,
  output logic [DW-1:0] result,
  output logic [15:0]   exc_code
);
  import ssr_pkg::*;

  localparam logic [AW-1:0] ORG_MASK = {1'b0, {(AW-7){1'b1}}, 6'b0};
  localparam logic [AW-1:0] OFF_4    = AW'(4);
  localparam logic [AW-1:0] OFF_8    = AW'(8);
  localparam logic [AW-1:0] OFF_12   = AW'(12);
  localparam logic [AW-1:0] OFF_20   = AW'(20);

  walk_st_t      st;
  logic [DW-1:0] des_q;
  logic [AW-1:0] asteo_q, pfx_q, lim_q, base_q, bas_org_q, sub_org_q;
  logic          act_q, inv_q;
  logic [31:0]   seq_q, e2_q, e3_q, e5_q;
  logic [AW-1:0] uct_org, sse_org;
  logic [DW-1:0] merge_res;
  logic [15:0]   merge_code;
  logic          busy;
  logic          unused_ctl0;

  assign busy        = (st != S_IDLE);
  assign unused_ctl0 = ^{ctl0[31:CTL_ENABLE_BIT+1], ctl0[CTL_ENABLE_BIT-1:0]};

  ssr_prefix #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_pfx_uct (
    .addr(AW'(ctl2) & ORG_MASK), .pfx(prefix_in), .phys(uct_org)
  );

  ssr_prefix #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_pfx_sse (
    .addr(sub_org_q), .pfx(pfx_q), .phys(sse_org)
  );

  ssr_merge #(.DW(DW), .EXT_MODE(EXT_MODE)) u_merge (
    .orig(des_q), .ent_invalid(inv_q), .ent_w2(e2_q), .ent_w3(e3_q),
    .ent_seq(e5_q), .ref_seq(seq_q), .res(merge_res), .code(merge_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      done      <= 1'b0;
      result    <= '0;
      exc_code  <= '0;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      des_q     <= '0;
      asteo_q   <= '0;
      pfx_q     <= '0;
      lim_q     <= '0;
      base_q    <= '0;
      bas_org_q <= '0;
      sub_org_q <= '0;
      act_q     <= 1'b0;
      inv_q     <= 1'b0;
      seq_q     <= '0;
      e2_q      <= '0;
      e3_q      <= '0;
      e5_q      <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            des_q   <= des_in;
            asteo_q <= asteo_in;
            pfx_q   <= prefix_in;
            lim_q   <= mem_limit;
            if (!ctl0[CTL_ENABLE_BIT] || !des_in[DES_GROUP_BIT]) begin
              done     <= 1'b1;
              result   <= des_in;
              exc_code <= '0;
            end else if (uct_org > mem_limit) begin
              done     <= 1'b1;
              result   <= '0;
              exc_code <= XC_ADDR;
            end else begin
              base_q   <= uct_org;
              mem_addr <= uct_org;
              mem_req  <= 1'b1;
              st       <= S_U0;
            end
          end
        end
        S_U0: if (mem_ack) begin
          bas_org_q <= AW'(mem_rdata) & ORG_MASK;
          mem_addr  <= base_q + OFF_4;
          st        <= S_U1;
        end
        S_U1: if (mem_ack) begin
          act_q     <= mem_rdata[ACTIVE_BIT];
          sub_org_q <= AW'(mem_rdata) & ORG_MASK;
          mem_addr  <= base_q + OFF_12;
          st        <= S_U3;
        end
        S_U3: if (mem_ack) begin
          seq_q   <= mem_rdata;
          mem_req <= 1'b0;
          st      <= S_UCHK;
        end
        S_UCHK: begin
          if (!act_q || asteo_q != bas_org_q) begin
            done     <= 1'b1;
            result   <= des_q;
            exc_code <= '0;
            st       <= S_IDLE;
          end else if (sse_org > lim_q) begin
            done     <= 1'b1;
            result   <= '0;
            exc_code <= XC_ADDR;
            st       <= S_IDLE;
          end else begin
            base_q   <= sse_org;
            mem_addr <= sse_org;
            mem_req  <= 1'b1;
            st       <= S_E0;
          end
        end
        S_E0: if (mem_ack) begin
          inv_q    <= mem_rdata[INVALID_BIT];
          mem_addr <= base_q + OFF_8;
          st       <= S_E2;
        end
        S_E2: if (mem_ack) begin
          e2_q <= mem_rdata;
          if (EXT_MODE != 0) begin
            mem_addr <= base_q + OFF_12;
            st       <= S_E3;
          end else begin
            mem_addr <= base_q + OFF_20;
            st       <= S_E5;
          end
        end
        S_E3: if (mem_ack) begin
          e3_q     <= mem_rdata;
          mem_addr <= base_q + OFF_20;
          st       <= S_E5;
        end
        S_E5: if (mem_ack) begin
          e5_q    <= mem_rdata;
          mem_req <= 1'b0;
          st      <= S_FIN;
        end
        S_FIN: begin
          done     <= 1'b1;
          result   <= merge_res;
          exc_code <= merge_code;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ssr_walker_chk.sv
module ssr_walker_chk #(
  parameter int AW = 32,
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic [31:0]   ctl0,
  input logic [DW-1:0] des_in,
  input logic          mem_req,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic          done,
  input logic [DW-1:0] result,
  input logic [15:0]   exc_code
);
  import ssr_pkg::*;

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_no_req_r12: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_req);

  p_addr_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  p_bypass_r1: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !ctl0[CTL_ENABLE_BIT])
      |=> (done && result == $past(des_in) && exc_code == 16'h0));

  // R3 R6 R8 R9: every exception completion carries a zero designator
  p_exc_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (done && exc_code != 16'h0) |-> (result == '0));
endmodule

bind ssr_walker ssr_walker_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .ctl0(ctl0),
  .des_in(des_in), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .done(done), .result(result), .exc_code(exc_code)
);

// File: tb/test_ssr_walker.sv
module test_ssr_walker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [63:0] des_in = '0;
  logic [31:0] asteo_in = '0, ctl0 = '0, ctl2 = '0, prefix_in = '0, mem_limit = '0;
  logic        mem_req, mem_ack = 1'b0, done;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic [63:0] result;
  logic [15:0] exc_code;

  int tests = 0, fails = 0, lat = 1, wcnt = 0, rcnt = 0;
  bit finished = 0;
  logic [31:0] mem  [0:4095];
  logic [31:0] rlog [0:255];

  always #5 clk = ~clk;

  ssr_walker i_ssr_walker (
    .clk(clk), .rst(rst), .start(start), .des_in(des_in), .asteo_in(asteo_in),
    .ctl0(ctl0), .ctl2(ctl2), .prefix_in(prefix_in), .mem_limit(mem_limit),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .done(done), .result(result), .exc_code(exc_code)
  );

  // memory model with programmable wait cycles, plus a log of completed reads
  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && mem_ack) begin
      rlog[rcnt[7:0]] <= mem_addr;
      rcnt <= rcnt + 1;
    end
    if (mem_req && !mem_ack) begin
      if (wcnt >= lat) begin
        mem_ack   <= 1'b1;
        mem_rdata <= mem[mem_addr[13:2]];
        wcnt      <= 0;
      end else wcnt <= wcnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    mem[a[13:2]] = d;
  endtask

  localparam logic [63:0] DES_OK = 64'h1111_2222_3333_0240;
  localparam logic [63:0] RES_OK = 64'hAAAA_0000_1234_5645;

  task automatic setup();
    ctl0 = 32'h0001_0000; ctl2 = 32'h0000_1000; prefix_in = 32'h0000_2000;
    mem_limit = 32'h0000_3FFF; asteo_in = 32'h0000_0C40; lat = 1;
    wr(32'h1000, 32'h0000_0C40); wr(32'h1004, 32'h8000_1800); wr(32'h100C, 32'h0000_0055);
    wr(32'h1800, 32'h0000_0000); wr(32'h1808, 32'hAAAA_0000);
    wr(32'h180C, 32'h1234_56C5); wr(32'h1814, 32'h0000_0055);
  endtask

  task automatic run(input logic [63:0] d, output logic [63:0] res, output logic [15:0] code,
                     output int lat_c, output int nrd, output int base);
    @(negedge clk);
    base = rcnt; des_in = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0; lat_c = 1;
    while (!done && lat_c < 200) begin @(negedge clk); lat_c++; end
    res = result; code = exc_code; nrd = rcnt - base;
    chk(done, "R12 done seen", 64'(done), 64'd1);
    chk(!mem_req, "R12 req low at done", 64'(mem_req), 64'd0);
    @(negedge clk);
    chk(!done, "R12 done one cycle", 64'(done), 64'd0);
  endtask

  task automatic chk_reads(input int base, input int n, input logic [31:0] exp [7], input string req);
    for (int i = 0; i < n; i++)
      chk(rlog[(base + i) % 256] == exp[i], req, 64'(rlog[(base + i) % 256]), 64'(exp[i]));
  endtask

  task automatic t_reset();
    chk(!done && !mem_req, "reset outputs idle", {62'd0, done, mem_req}, 64'd0);
    chk(result == 0 && exc_code == 0, "reset values", result, 64'd0);
  endtask

  task automatic t_bypass_enable();
    logic [63:0] r; logic [15:0] c; int l, n, b;
    setup(); ctl0 = 32'hFFFE_FFFF;
    run(DES_OK, r, c, l, n, b);
    chk(r == DES_OK && c == 0, "R1 result", r, DES_OK);
    chk(l == 1, "R1 latency", 64'(l), 64'd1);
    chk(n == 0, "R1 no reads", 64'(n), 64'd0);
  endtask

  task automatic t_bypass_group();
    logic [63:0] r; logic [15:0] c; int l, n, b;
    setup();
    run(64'h5555_0000_0000_FDC0, r, c, l, n, b);
    chk(r == 64'h5555_0000_0000_FDC0 && c == 0, "R2 result", r, 64'h5555_0000_0000_FDC0);
    chk(l == 1 && n == 0, "R2 latency/no reads", {32'(l), 32'(n)}, {32'd1, 32'd0});
  endtask

  task automatic t_uct_limit();
    logic [63:0] r; logic [15:0] c; int l, n, b;
    setup(); mem_limit = 32'h0000_0FFF;
    run(DES_OK, r, c, l, n, b);
    chk(r == 0 && c == 16'h0005, "R3 addressing", {r[47:0], c}, {48'd0, 16'h0005});
    chk(n == 0, "R3 no reads", 64'(n), 64'd0);
  endtask

  task automatic t_inactive();
    logic [63:0] r; logic [15:0] c; int l, n, b;
    logic [31:0] e [7] = '{32'h1000, 32'h1004, 32'h100C, 0, 0, 0, 0};
    setup(); wr(32'h1004, 32'h0000_1800); lat = 0;
    run(DES_OK, r, c, l, n, b);
    chk(r == DES_OK && c == 0, "R5 inactive unchanged", r, DES_OK);
    chk(n == 3, "R4 three control reads", 64'(n), 64'd3);
    chk_reads(b, 3, e, "R4 control read order");
  endtask

  task automatic t_base_mismatch();
    logic [63:0] r; logic [15:0] c; int l, n, b;
    setup(); asteo_in = 32'h0000_0C80; lat = 2;
    run(DES_OK, r, c, l, n, b);
    chk(r == DES_OK && c == 0 && n == 3, "R5 base mismatch", r, DES_OK);
  endtask

  task automatic t_sse_limit();
    logic [63:0] r; logic [15:0] c; int l, n, b;
    setup(); wr(32'h1004, 32'h8000_7000);
    run(DES_OK, r, c, l, n, b);
    chk(r == 0 && c == 16'h0005, "R6 addressing", {r[47:0], c}, {48'd0, 16'h0005});
    chk(n == 3, "R6 reads", 64'(n), 64'd3);
  endtask

  task automatic t_success();
    logic [63:0] r; logic [15:0] c; int l, n, b;
    logic [31:0] e [7] = '{32'h1000, 32'h1004, 32'h100C, 32'h1800, 32'h1808, 32'h180C, 32'h1814};
    setup(); lat = 2;
    run(DES_OK, r, c, l, n, b);
    chk(r == RES_OK && c == 0, "R10 merged result", r, RES_OK);
    chk(n == 7, "R7 seven reads", 64'(n), 64'd7);
    chk_reads(b, 7, e, "R7 read order");
  endtask

  task automatic t_invalid();
    logic [63:0] r; logic [15:0] c; int l, n, b;
    setup(); wr(32'h1800, 32'h8000_0000); wr(32'h1814, 32'h0000_0099);
    run(DES_OK, r, c, l, n, b);
    chk(r == 0 && c == 16'h002B, "R8 validity priority", {r[47:0], c}, {48'd0, 16'h002B});
  endtask

  task automatic t_sequence();
    logic [63:0] r; logic [15:0] c; int l, n, b;
    setup(); wr(32'h1814, 32'h0000_0056);
    run(DES_OK, r, c, l, n, b);
    chk(r == 0 && c == 16'h002C, "R9 sequence", {r[47:0], c}, {48'd0, 16'h002C});
  endtask

  task automatic t_prefix();
    logic [63:0] r; logic [15:0] c; int l, n, b;
    logic [31:0] e [7] = '{32'h2100, 32'h2104, 32'h210C, 32'h0300, 32'h0308, 32'h030C, 32'h0314};
    setup(); ctl2 = 32'h0000_0100;
    wr(32'h2100, 32'h0000_0C40); wr(32'h2104, 32'h8000_2300); wr(32'h210C, 32'h0000_0077);
    wr(32'h0300, 32'h0); wr(32'h0308, 32'h0000_0001); wr(32'h030C, 32'h0000_0000);
    wr(32'h0314, 32'h0000_0077);
    run(64'h0000_0000_0000_02C0, r, c, l, n, b);
    chk(r == 64'h0000_0001_0000_00C0 && c == 0, "R11 prefixed result", r, 64'h0000_0001_0000_00C0);
    chk(n == 7, "R11 reads", 64'(n), 64'd7);
    chk_reads(b, 7, e, "R11 swapped addresses");
  endtask

  task automatic t_busy();
    int cnt = 0;
    logic [63:0] r = '0;
    setup();
    @(negedge clk); des_in = DES_OK; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    ctl0 = 32'h0; des_in = 64'hDEAD; start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 60; i++) begin
      if (done) begin cnt++; r = result; end
      @(negedge clk);
    end
    chk(cnt == 1, "R13 single done", 64'(cnt), 64'd1);
    chk(r == RES_OK, "R13 first result kept", r, RES_OK);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_bypass_enable();
    t_bypass_group();
    t_uct_limit();
    t_inactive();
    t_base_mismatch();
    t_sse_limit();
    t_success();
    t_invalid();
    t_sequence();
    t_prefix();
    t_busy();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule